// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects interrupt requests from a parameterised number of channels. Each channel owns one 16-bit control word. The word holds a pending flag, a mask bit and a 4-bit priority. A rising edge on a channel's hardware request line sets the flag. Software can also set or clear the flag through a small register port. Every cycle an arbiter picks one channel among those that are pending and unmasked. It takes the one with the numerically smallest priority value, and on a tie the lowest channel index. The chosen channel ID and its priority are offered to the CPU over a valid/ready handshake.

The CPU side is a valid/ready stream. While `irq_valid` is high, `irq_id` and `irq_prio` name the current winner. A transfer happens on a clock edge where both `irq_valid` and `irq_ready` are high, and it clears the pending flag of the channel named at that edge. The winner is not held while the CPU waits. If a more urgent request arrives, or the winner is masked, the offer changes or is withdrawn before acceptance. `irq_ready` applies only to what is presented, and is ignored while `irq_valid` is low.

The mask bits can also be reached through a packed mask view, one bit per channel, 16 channels per word. A write through either the control word or the packed view updates the single stored mask bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control word reads 0x008F: flag 0, mask 1, priority 15. Every packed mask word reads 0xFFFF for existing channels. `irq_valid` and `pend_any` are 0.
- R2: Control word layout: bit 12 is the pending flag, bit 7 is the mask, bits 3..0 are the priority. All other bits read 0 and ignore writes.
- R3: `bus_be[1]` enables the write of bits 15..8 and `bus_be[0]` enables the write of bits 7..0. A byte that is not enabled keeps its contents.
- R4: A 0-to-1 transition on `hw_irq[c]` sets flag c, even while channel c is masked. A level held high does not set the flag again after it has been cleared.
- R5: A software write of 1 to the flag bit raises a request exactly as a hardware edge does. A software write of 0 clears the flag.
- R6: A masked channel is never presented on the CPU interface, whatever the state of its flag.
- R7: The presented channel has the smallest priority value among pending unmasked channels. On equal values the lowest channel index wins.
- R8: `pend_any` is 1 exactly when at least one channel is both pending and unmasked.
- R9: Address bit CH_AW selects the region: 0 for the control word of channel `bus_addr[CH_AW-1:0]`, 1 for packed mask word w = `bus_addr[CH_AW-1:0]`. Bit b of word w is the mask of channel 16*w+b. Writes through either view update the same bit.
- R10: A transfer (valid and ready high at an edge) clears the flag of the presented channel. A hardware edge on that channel at the same edge wins and leaves the flag set. A software write of the flag at that edge overrides the clear.
- R11: The CPU interface and `pend_any` reflect a hardware edge, register write or transfer at the first clock edge that samples it.
- R12: `irq_ready` while `irq_valid` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NUM_CH | Hardware request lines, rising edge sets the flag |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | CH_AW+1 | Region bit and index |
| bus_be | input | 2 | Byte enables (1 = high byte, 0 = low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word, 0 when not reading |
| irq_valid | output | 1 | A pending unmasked channel is presented |
| irq_ready | input | 1 | CPU accepts the presented channel |
| irq_id | output | CH_AW | Presented channel index |
| irq_prio | output | 4 | Priority of the presented channel |
| pend_any | output | 1 | Some unmasked channel is pending |

## Verification
Flag, mask and priority changes take effect at the edge that samples the stimulus. The registered arbitration output follows at that same edge, so each result is due one edge after its cause. Read data is combinational from the stored words and is due within the same cycle. The bench drives inputs just after the falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, so each comparison lands exactly one sampling edge after the stimulus it depends on.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CTRL_W   = 16;
  localparam int PRIO_W   = 4;
  localparam int FLAG_BIT = 12;
  localparam int MASK_BIT = 7;
  localparam int PRIO_LSB = 0;
  localparam int MWORD_W  = 16;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  flag;
    logic  mask;
    prio_t prio;
  } chan_t;

  localparam chan_t CHAN_RST = '{flag: 1'b0, mask: 1'b1, prio: {PRIO_W{1'b1}}};

  function automatic logic [CTRL_W-1:0] pack_ctrl(chan_t s);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[FLAG_BIT] = s.flag;
    r[MASK_BIT] = s.mask;
    r[PRIO_LSB +: PRIO_W] = s.prio;
    return r;
  endfunction
endpackage

// File: rtl/irq_chan_reg.sv
module irq_chan_reg
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hw_in,
  input  logic  ack_clr,
  input  logic  wr_hi,
  input  logic  wr_lo,
  input  logic  wflag,
  input  logic  wmask,
  input  prio_t wprio,
  input  logic  mask_wr,
  input  logic  mask_wbit,
  output chan_t st_q,
  output chan_t st_d
);
  logic in_q;
  logic edge_s;

  assign edge_s = hw_in & ~in_q;

  // precedence for the flag: transfer clear < software write < hardware edge
  always_comb begin
    st_d = st_q;
    if (ack_clr) st_d.flag = 1'b0;
    if (wr_hi)   st_d.flag = wflag;
    if (edge_s)  st_d.flag = 1'b1;
    if (wr_lo) begin
      st_d.mask = wmask;
      st_d.prio = wprio;
    end
    if (mask_wr) st_d.mask = mask_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CHAN_RST;
      in_q <= 1'b0;
    end else begin
      st_q <= st_d;
      in_q <= hw_in;
    end
  end

  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_s |=> st_q.flag);

  p_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wflag) |=> st_q.flag);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !edge_s && !wr_hi) |=> !st_q.flag);

  p_prio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(st_q.prio));
endmodule

// File: rtl/irq_bus_if.sv
module irq_bus_if
  import irq_pkg::*;
#(
  parameter  int NUM_CH = 32,
  localparam int CH_AW  = $clog2(NUM_CH),
  localparam int MW     = (NUM_CH + MWORD_W - 1) / MWORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [CH_AW:0]        bus_addr,
  input  logic [1:0]            bus_be,
  input  logic [CTRL_W-1:0]     bus_wdata,
  input  chan_t [NUM_CH-1:0]    st_q,
  output logic  [NUM_CH-1:0]    wr_hi,
  output logic  [NUM_CH-1:0]    wr_lo,
  output logic  [NUM_CH-1:0]    mask_wr,
  output logic  [NUM_CH-1:0]    mask_wbit,
  output logic  [CTRL_W-1:0]    bus_rdata
);
  logic             region;
  logic [CH_AW-1:0] idx;
  logic             wr_s;
  logic [MW*MWORD_W-1:0] mask_pad;

  assign region = bus_addr[CH_AW];
  assign idx    = bus_addr[CH_AW-1:0];
  assign wr_s   = bus_en & bus_we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign wr_hi[c]     = wr_s & ~region & (idx == CH_AW'(c)) & bus_be[1];
    assign wr_lo[c]     = wr_s & ~region & (idx == CH_AW'(c)) & bus_be[0];
    assign mask_wr[c]   = wr_s & region & (idx == CH_AW'(c / MWORD_W))
                          & bus_be[(c % MWORD_W) / 8];
    assign mask_wbit[c] = bus_wdata[c % MWORD_W];
  end

  for (genvar b = 0; b < MW*MWORD_W; b++) begin : g_pad
    if (b < NUM_CH) begin : g_real
      assign mask_pad[b] = st_q[b].mask;
    end else begin : g_zero
      assign mask_pad[b] = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (!region) begin
        if (int'(idx) < NUM_CH) bus_rdata = pack_ctrl(st_q[idx]);
      end else begin
        if (int'(idx) < MW) bus_rdata = mask_pad[int'(idx)*MWORD_W +: MWORD_W];
      end
    end
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !region) |-> ((bus_rdata & 16'hEF70) == 16'h0000));

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_lo | mask_wr) || (wr_lo == '0) || (mask_wr == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter  int NUM_CH = 32,
  localparam int CH_AW  = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chan_t [NUM_CH-1:0] st_d,
  output logic               out_valid,
  output logic [CH_AW-1:0]   out_id,
  output prio_t              out_prio
);
  logic [NUM_CH-1:0] pend;
  logic              found;
  logic [CH_AW-1:0]  best_id;
  prio_t             best_p;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    assign pend[c] = st_d[c].flag & ~st_d[c].mask;
  end

  // ascending scan, strict compare keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend[i] && (!found || st_d[i].prio < best_p)) begin
        found   = 1'b1;
        best_p  = st_d[i].prio;
        best_id = CH_AW'(i);
      end
    end
  end

  always_comb begin
    if (rst_n) begin
      p_found_r6: assert (found == (|pend));
      if (found) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (pend[i]) begin
            p_tie_order_r7: assert (!(st_d[i].prio < best_p) &&
              !((st_d[i].prio == best_p) && (CH_AW'(i) < best_id)));
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_id    <= '0;
      out_prio  <= '1;
    end else begin
      out_valid <= found;
      out_id    <= best_id;
      out_prio  <= best_p;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter  int NUM_CH = 32,
  localparam int CH_AW  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_irq,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [CH_AW:0]    bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [CH_AW-1:0]  irq_id,
  output logic [3:0]        irq_prio,
  output logic              pend_any
);
  chan_t [NUM_CH-1:0] st_q;
  chan_t [NUM_CH-1:0] st_d;
  logic  [NUM_CH-1:0] wr_hi, wr_lo, mask_wr, mask_wbit, ack_clr, live;
  prio_t              arb_prio;

  irq_bus_if #(.NUM_CH(NUM_CH)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .st_q      (st_q),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .mask_wr   (mask_wr),
    .mask_wbit (mask_wbit),
    .bus_rdata (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ack_clr[c] = irq_valid & irq_ready & (irq_id == CH_AW'(c));
    assign live[c]    = st_q[c].flag & ~st_q[c].mask;

    irq_chan_reg u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_in     (hw_irq[c]),
      .ack_clr   (ack_clr[c]),
      .wr_hi     (wr_hi[c]),
      .wr_lo     (wr_lo[c]),
      .wflag     (bus_wdata[FLAG_BIT]),
      .wmask     (bus_wdata[MASK_BIT]),
      .wprio     (bus_wdata[PRIO_LSB +: PRIO_W]),
      .mask_wr   (mask_wr[c]),
      .mask_wbit (mask_wbit[c]),
      .st_q      (st_q[c]),
      .st_d      (st_d[c])
    );
  end

  irq_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_d      (st_d),
    .out_valid (irq_valid),
    .out_id    (irq_id),
    .out_prio  (arb_prio)
  );

  assign irq_prio = arb_prio;
  assign pend_any = |live;

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !st_q[irq_id].mask);

  p_winner_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (st_q[irq_id].flag && (st_q[irq_id].prio == irq_prio)));

  p_pend_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any == irq_valid);

  p_idle_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && irq_ready && !bus_en && (hw_irq == '0)) |=> $stable(st_q));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NUM_CH = 32;
  localparam int CH_AW  = $clog2(NUM_CH);
  localparam int MW     = (NUM_CH + 15) / 16;
  localparam time CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] hw_irq = '0;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [CH_AW:0]    bus_addr = '0;
  logic [1:0]        bus_be = '0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              irq_valid, irq_ready = 1'b0, pend_any;
  logic [CH_AW-1:0]  irq_id;
  logic [3:0]        irq_prio;

  int n_chk = 0, n_fail = 0;
  bit checking = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_CH(NUM_CH)) dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id),
    .irq_prio(irq_prio), .pend_any(pend_any)
  );

  // behavioural reference model
  bit       m_flag [NUM_CH];
  bit       m_mask [NUM_CH];
  bit [3:0] m_prio [NUM_CH];
  bit       m_inq  [NUM_CH];
  bit       m_valid;
  int       m_id, m_po;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [CH_AW:0] a);
    int ix;
    logic [15:0] r;
    ix = int'(a[CH_AW-1:0]);
    r = '0;
    if (!a[CH_AW]) begin
      if (ix < NUM_CH) r = {3'b0, m_flag[ix], 4'b0, m_mask[ix], 3'b0, m_prio[ix]};
    end else if (ix < MW) begin
      for (int b = 0; b < 16; b++)
        if (ix*16 + b < NUM_CH) r[b] = m_mask[ix*16 + b];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        m_flag[c] = 0; m_mask[c] = 1; m_prio[c] = 4'hF; m_inq[c] = 0;
      end
      m_valid = 0; m_id = 0; m_po = 15;
    end else begin
      int ix, best;
      ix = int'(bus_addr[CH_AW-1:0]);
      for (int c = 0; c < NUM_CH; c++) begin
        if (m_valid && irq_ready && m_id == c) m_flag[c] = 0;
        if (bus_en && bus_we && !bus_addr[CH_AW] && ix == c) begin
          if (bus_be[1]) m_flag[c] = bus_wdata[12];
          if (bus_be[0]) begin m_mask[c] = bus_wdata[7]; m_prio[c] = bus_wdata[3:0]; end
        end
        if (bus_en && bus_we && bus_addr[CH_AW] && ix == c / 16 && bus_be[(c % 16) / 8])
          m_mask[c] = bus_wdata[c % 16];
        if (hw_irq[c] && !m_inq[c]) m_flag[c] = 1;
        m_inq[c] = hw_irq[c];
      end
      best = 16; m_valid = 0;
      for (int c = 0; c < NUM_CH; c++)
        if (m_flag[c] && !m_mask[c] && m_prio[c] < best) begin
          best = m_prio[c]; m_id = c; m_valid = 1;
        end
      if (m_valid) m_po = best;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk("R6 valid", irq_valid, m_valid);
      chk("R8 pend_any", pend_any, m_valid);
      if (m_valid) begin
        chk("R7 id", irq_id, m_id);
        chk("R7 prio", irq_prio, m_po);
      end
      if (bus_en && !bus_we) chk("R2 rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input int region, input int ix, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); #1;
    bus_en = 1; bus_we = 1; bus_addr = {region[0], CH_AW'(ix)}; bus_be = be; bus_wdata = d;
    @(negedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int region, input int ix, output logic [15:0] d);
    @(negedge clk); #1;
    bus_en = 1; bus_we = 0; bus_addr = {region[0], CH_AW'(ix)};
    #2 d = bus_rdata;
    @(negedge clk); #1;
    bus_en = 0;
  endtask

  task automatic accept();
    @(negedge clk); #1 irq_ready = 1;
    @(negedge clk); #1 irq_ready = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at %0t: got hang expected completion", $time);
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    checking = 1;

    // R1: reset contents
    chk("R1 valid", irq_valid, 0);
    chk("R1 pend", pend_any, 0);
    for (int c = 0; c < NUM_CH; c++) begin rd(0, c, d); chk("R1 ctrl", d, 16'h008F); end
    for (int w = 0; w < MW; w++) begin rd(1, w, d); chk("R1 maskword", d, 16'hFFFF); end

    // R2: reserved bits; R6: masked pending not presented
    wr(0, 3, 2'b11, 16'hFFFF);
    rd(0, 3, d); chk("R2 layout", d, 16'h108F);
    chk("R6 masked", irq_valid, 0);

    // R3: low byte only; R11: presented one edge after the write
    wr(0, 3, 2'b01, 16'hFF05);
    chk("R11 valid", irq_valid, 1);
    chk("R11 id", irq_id, 3);
    rd(0, 3, d); chk("R3 lowbyte", d, 16'h1005);

    // R10: transfer clears the flag
    accept();
    chk("R10 valid", irq_valid, 0);
    rd(0, 3, d); chk("R10 cleared", d, 16'h0005);

    // R5: software set and clear
    wr(0, 3, 2'b10, 16'h1000);
    chk("R5 set valid", irq_valid, 1);
    chk("R5 set id", irq_id, 3);
    wr(0, 3, 2'b10, 16'h0000);
    rd(0, 3, d); chk("R5 clear", d, 16'h0005);

    // R4: edge on masked channel latches
    @(negedge clk); #1 hw_irq[7] = 1;
    repeat (2) @(negedge clk);
    chk("R4 masked valid", irq_valid, 0);
    rd(0, 7, d); chk("R4 latched", d, 16'h108F);

    // R9: packed mask view
    wr(1, 0, 2'b11, 16'hFF7F);
    rd(0, 7, d); chk("R9 ctrl mirror", d, 16'h100F);
    chk("R9 id", irq_id, 7);
    accept();
    rd(0, 7, d); chk("R4 held level", d, 16'h000F);
    @(negedge clk); #1 hw_irq[7] = 0;
    @(negedge clk); #1 hw_irq[7] = 1;
    @(negedge clk);
    chk("R4 re-edge", irq_id, 7);

    // R7: tie goes to lower index, lower value wins
    wr(0, 9, 2'b01, 16'h0002);
    wr(0, 5, 2'b01, 16'h0002);
    wr(0, 9, 2'b10, 16'h1000);
    chk("R7 id9", irq_id, 9);
    wr(0, 5, 2'b10, 16'h1000);
    chk("R7 tie id", irq_id, 5);
    chk("R7 tie prio", irq_prio, 2);
    rd(1, 0, d); chk("R9 maskword", d, 16'hFD5F);
    wr(0, 20, 2'b01, 16'h0001);
    wr(0, 20, 2'b10, 16'h1000);
    chk("R7 lower value", irq_id, 20);
    rd(1, 1, d); chk("R9 maskword1", d, 16'hFFEF);

    // R10: simultaneous edge keeps flag
    @(negedge clk); #1 irq_ready = 1; hw_irq[20] = 1;
    @(negedge clk); #1 irq_ready = 0;
    chk("R10 edge wins", irq_id, 20);
    rd(0, 20, d); chk("R10 edge wins flag", d, 16'h1001);

    // R12: ready while idle; R8 pending status
    wr(1, 0, 2'b11, 16'hFFFF);
    wr(1, 1, 2'b11, 16'hFFFF);
    chk("R8 all masked", pend_any, 0);
    accept();
    wr(1, 1, 2'b11, 16'hFFEF);
    chk("R12 kept", irq_id, 20);
    chk("R8 pend", pend_any, 1);
    rd(0, 20, d); chk("R12 flag", d, 16'h1001);

    // mixed traffic against the model
    @(negedge clk); #1 hw_irq = '0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      for (int i = 0; i < NUM_CH; i++) hw_irq[i] = ($urandom % 5 == 0);
      irq_ready = ($urandom % 2 == 1);
      bus_en    = ($urandom % 3 == 0);
      bus_we    = ($urandom % 2 == 1);
      if ($urandom % 3 == 0)
        bus_addr = {1'b1, CH_AW'($urandom % MW)};
      else
        bus_addr = {1'b0, CH_AW'($urandom % NUM_CH)};
      bus_be    = 2'($urandom);
      bus_wdata = 16'($urandom);
      if ($urandom % 2 == 1) bus_wdata[3:0] = 4'($urandom % 3);
    end
    @(negedge clk); #1 bus_en = 0; irq_ready = 0; hw_irq = '0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule